// File: doc/BRIEF.md
# Buffered Synchronous Serial Shifter

This block is an 8-bit serial port for 2-wire or 3-wire NRZ links. One shift register sits between a transmit holding buffer, written by the host, and a receive holding buffer, read by the host. The host steers the port with level controls: a port-off bit, a transfer direction, a clock-edge choice, internal or external shift clock, the internal clock source, an interrupt mask and an interrupt cause.

When the needed buffer is not serviced, shifting stops instead of overrunning. In transmit direction the port waits for a fresh byte. In receive direction a completed byte waits in the shift register until the host has read the previous one. Turning the port off in the middle of a telegram stops the shift clock and copies the bits gathered so far into the receive buffer. This lets the host take in telegrams shorter than eight bits. A single-cycle interrupt marks either the ready flag falling or the end of every telegram.

Top module: `sync_shift_port`

## Requirements
- R1: A telegram is 8 bits sent most significant bit first. At telegram start the transmit buffer is copied into the shift register, and bit 7 appears on `sd_out` before the first capture edge.
- R2: After reset, `ready`, `active` and `irq` are 0 and both buffers are empty. `ready` reads 1 when the transmit buffer is full if `dir_tx`=1, and 1 when the receive buffer is empty if `dir_tx`=0.
- R3: With `dir_tx`=1 a telegram starts only after a `tx_wr` pulse has filled the transmit buffer. With the buffer empty, `active` stays 0.
- R4: With `dir_tx`=0, a telegram that completes while the receive buffer is still full is held in the shift register and shifting stops. After `rx_rd`, `ready` reads 1 for one cycle, then the held byte moves into the receive buffer and reception resumes.
- R5: Raising `port_off` while `active`=1 clears `active` at the next edge. It also copies the shift register into the receive buffer and marks that buffer full. In receive direction the bits taken so far sit right-aligned over zeros.
- R6: With `edge_rise`=1 data changes on the rising edge of the shift clock and is sampled on the falling edge, and the idle clock level is high. With `edge_rise`=0 both edges and the idle level are inverted.
- R7: With `clk_int`=1 the port drives `sck_out` (`sck_oe`=1). With `clk_src`=0 the shift clock toggles on every system clock cycle, so one 8-bit telegram keeps `active` high for 16 cycles. With `clk_src`=1 it toggles once per rising edge of `timer_in`.
- R8: `irq` is a one-cycle pulse. With `irq_on_end`=0 it fires when `ready` falls. With `irq_on_end`=1 it fires at the end of each telegram. `irq_mask`=1 suppresses it.
- R9: `active` is high from the telegram load until the last clock edge of the telegram, and the shift clock returns to idle when it drops.
- R10: With `dir_tx`=0 and `port_off`=0, reception starts by itself. The first completed byte appears on `rx_data` with `ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_off | input | 1 | 1 holds the port inactive; rising mid-telegram latches a partial byte |
| dir_tx | input | 1 | 1 transmit direction, 0 receive direction |
| edge_rise | input | 1 | 1 data changes on rising shift-clock edge, 0 on falling |
| clk_int | input | 1 | 1 internal shift clock driven out, 0 external clock sampled |
| clk_src | input | 1 | Internal source: 0 system clock / 2, 1 timer input / 2 |
| timer_in | input | 1 | Timer output used as clock source |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| irq_on_end | input | 1 | 1 interrupt at telegram end, 0 on ready falling |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte written to the transmit buffer |
| rx_rd | input | 1 | Read strobe that frees the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| ready | output | 1 | Buffer ready flag, meaning set by direction |
| active | output | 1 | Telegram in progress |
| irq | output | 1 | Single-cycle interrupt pulse |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock |
| sck_oe | output | 1 | Shift clock pin drive enable |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data pin drive enable |

## Verification
The properties assume that `edge_rise` and `dir_tx` change only while no telegram runs. The idle-level check only looks at cycles where `edge_rise` has been steady for a cycle. The data checks assume that an external shift clock holds each phase for longer than the synchronizer latency, and that `sd_in` settles before the capture edge. The stimulus changes configuration only with `port_off` high or the port idle. It holds every external clock phase for four system cycles and drives data one phase ahead of each capture edge.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

    // Shift-clock events seen by the shifter in one system cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CAP  = 2'd1,   // capture edge: sample incoming bit
        EV_LAU  = 2'd2    // launch edge: present next outgoing bit
    } shift_ev_e;

    localparam int unsigned SSP_SYNC_STAGES = 2;

endpackage

// File: rtl/ssp_sync.sv
`timescale 1ns/1ps
module ssp_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SSP_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      idle_lvl_i,
    input  logic      int_i,
    input  logic      tmr_sel_i,
    input  logic      tmr_i,
    input  logic      sck_i,
    input  logic      sd_i,
    output logic      sck_o,
    output logic      sd_o,
    output shift_ev_e ev_o
);
    localparam int unsigned NSYNC = 3;

    logic [NSYNC-1:0] raw, synced;
    logic s_tmr, s_sck;

    assign raw = {tmr_i, sck_i, sd_i};

    ssp_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign {s_tmr, s_sck, sd_o} = synced;

    typedef struct packed {
        logic sck;
        logic tmr_prev;
        logic sck_prev;
    } cg_t;

    cg_t  cg_d, cg_q;
    logic tick, ext_rise, ext_fall;

    always_comb begin
        cg_d          = cg_q;
        cg_d.tmr_prev = s_tmr;
        cg_d.sck_prev = s_sck;
        tick     = tmr_sel_i ? (s_tmr & ~cg_q.tmr_prev) : 1'b1;
        ext_rise = s_sck & ~cg_q.sck_prev;
        ext_fall = ~s_sck & cg_q.sck_prev;
        ev_o     = EV_NONE;
        if (run_i) begin
            if (int_i) begin
                if (tick) ev_o = (cg_q.sck == idle_lvl_i) ? EV_CAP : EV_LAU;
            end else begin
                if (idle_lvl_i ? ext_fall : ext_rise)      ev_o = EV_CAP;
                else if (idle_lvl_i ? ext_rise : ext_fall) ev_o = EV_LAU;
            end
        end
        if (run_i && int_i) begin
            if (ev_o != EV_NONE) cg_d.sck = ~cg_q.sck;
        end else begin
            cg_d.sck = idle_lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '{sck: 1'b1, tmr_prev: 1'b0, sck_prev: 1'b0};
        else        cg_q <= cg_d;
    end

    assign sck_o = cg_q.sck;
endmodule

// File: rtl/ssp_core.sv
`timescale 1ns/1ps
module ssp_core
    import ssp_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_off_i,
    input  logic          dir_tx_i,
    input  logic          irq_mask_i,
    input  logic          irq_end_i,
    input  logic          tx_wr_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          rx_rd_i,
    input  shift_ev_e     ev_i,
    input  logic          sd_i,
    output logic [DW-1:0] rx_data_o,
    output logic          ready_o,
    output logic          busy_o,
    output logic          irq_o,
    output logic          sd_o
);
    localparam int unsigned CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);

    typedef struct packed {
        logic             busy;
        logic             hold;
        logic             txfull;
        logic             rxfull;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    sr;
        logic             out;
        logic [DW-1:0]    txbuf;
        logic [DW-1:0]    rxbuf;
        logic             irq;
    } st_t;

    st_t  st_d, st_q;
    logic tel_end, rdy_now, rdy_nxt;

    always_comb begin
        st_d    = st_q;
        tel_end = 1'b0;
        if (rx_rd_i) st_d.rxfull = 1'b0;
        if (port_off_i) begin
            if (st_q.busy) begin
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
                st_d.rxbuf  = st_q.sr;
                st_d.rxfull = 1'b1;
            end
        end else if (st_q.busy) begin
            if (ev_i == EV_CAP) begin
                st_d.sr  = {st_q.sr[DW-2:0], sd_i};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else if (ev_i == EV_LAU) begin
                if (st_q.cnt == CNT_FULL) begin
                    tel_end   = 1'b1;
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                    if (!dir_tx_i) begin
                        if (st_q.rxfull) begin
                            st_d.hold = 1'b1;
                        end else begin
                            st_d.rxbuf  = st_q.sr;
                            st_d.rxfull = 1'b1;
                        end
                    end
                end else begin
                    st_d.out = st_q.sr[DW-1];
                end
            end
        end else if (st_q.hold) begin
            if (!st_q.rxfull) begin
                st_d.rxbuf  = st_q.sr;
                st_d.rxfull = 1'b1;
                st_d.hold   = 1'b0;
            end
        end else if (dir_tx_i ? st_q.txfull : 1'b1) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            if (dir_tx_i) begin
                st_d.sr     = st_q.txbuf;
                st_d.out    = st_q.txbuf[DW-1];
                st_d.txfull = 1'b0;
            end else begin
                st_d.sr  = '0;
                st_d.out = 1'b0;
            end
        end
        if (tx_wr_i) begin
            st_d.txbuf  = tx_data_i;
            st_d.txfull = 1'b1;
        end
        rdy_now  = dir_tx_i ? st_q.txfull : ~st_q.rxfull;
        rdy_nxt  = dir_tx_i ? st_d.txfull : ~st_d.rxfull;
        st_d.irq = ~irq_mask_i & (irq_end_i ? tel_end : (rdy_now & ~rdy_nxt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data_o = st_q.rxbuf;
    assign ready_o   = dir_tx_i ? st_q.txfull : ~st_q.rxfull;
    assign busy_o    = st_q.busy;
    assign irq_o     = st_q.irq;
    assign sd_o      = st_q.out;
endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = SSP_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_off,
    input  logic              dir_tx,
    input  logic              edge_rise,
    input  logic              clk_int,
    input  logic              clk_src,
    input  logic              timer_in,
    input  logic              irq_mask,
    input  logic              irq_on_end,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              ready,
    output logic              active,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe
);
    shift_ev_e ev;
    logic      sd_sync;

    ssp_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (active),
        .idle_lvl_i (edge_rise),
        .int_i      (clk_int),
        .tmr_sel_i  (clk_src),
        .tmr_i      (timer_in),
        .sck_i      (sck_in),
        .sd_i       (sd_in),
        .sck_o      (sck_out),
        .sd_o       (sd_sync),
        .ev_o       (ev)
    );

    ssp_core #(.DW(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_off_i (port_off),
        .dir_tx_i   (dir_tx),
        .irq_mask_i (irq_mask),
        .irq_end_i  (irq_on_end),
        .tx_wr_i    (tx_wr),
        .tx_data_i  (tx_data),
        .rx_rd_i    (rx_rd),
        .ev_i       (ev),
        .sd_i       (sd_sync),
        .rx_data_o  (rx_data),
        .ready_o    (ready),
        .busy_o     (active),
        .irq_o      (irq),
        .sd_o       (sd_out)
    );

    assign sck_oe = clk_int;
    assign sd_oe  = dir_tx;
endmodule

// File: rtl/sync_shift_port_checks.sv
`timescale 1ns/1ps
module sync_shift_port_checks (
    input logic clk,
    input logic rst_n,
    input logic port_off,
    input logic dir_tx,
    input logic edge_rise,
    input logic irq_mask,
    input logic sck_oe,
    input logic sck_out,
    input logic ready,
    input logic active,
    input logic irq
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: an empty transmit buffer never starts a telegram
    a_r3_no_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_off && dir_tx && !ready && !active) |=> !active);

    // R5: turning the port off ends a running telegram at the next edge
    a_r5_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (active && port_off) |=> !active);

    // R8: the interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: a masked interrupt never reaches the output
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq) |-> !$past(irq_mask));

    // R6: between telegrams the driven shift clock sits at its idle level
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sck_oe && !active && !$past(active) && $stable(edge_rise))
        |-> (sck_out == edge_rise));
endmodule

bind sync_shift_port sync_shift_port_checks chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_off  (port_off),
    .dir_tx    (dir_tx),
    .edge_rise (edge_rise),
    .irq_mask  (irq_mask),
    .sck_oe    (sck_oe),
    .sck_out   (sck_out),
    .ready     (ready),
    .active    (active),
    .irq       (irq)
);

// File: tb/sync_shift_port_test.sv
`timescale 1ns/1ps
module sync_shift_port_test;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, port_off = 1'b1, dir_tx = 1'b1, edge_rise = 1'b1;
    logic clk_int = 1'b1, clk_src = 1'b0, timer_in = 1'b0;
    logic irq_mask = 1'b0, irq_on_end = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [DW-1:0] tx_data = '0, rx_data;
    logic ready, active, irq, sck_in = 1'b1, sck_out, sck_oe, sd_in = 1'b0, sd_out, sd_oe;

    sync_shift_port uut (
        .clk(clk), .rst_n(rst_n), .port_off(port_off), .dir_tx(dir_tx),
        .edge_rise(edge_rise), .clk_int(clk_int), .clk_src(clk_src),
        .timer_in(timer_in), .irq_mask(irq_mask), .irq_on_end(irq_on_end),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .ready(ready), .active(active), .irq(irq), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sd_in(sd_in), .sd_out(sd_out),
        .sd_oe(sd_oe)
    );

    int n_chk = 0, n_bad = 0, irq_total = 0;
    logic [15:0] g_bits;
    int g_nb, g_act, g_irq;
    logic g_pv;
    bit done = 1'b0;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            timer_in = ~timer_in;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (irq) irq_total++;
    endtask

    // watch n cycles, gathering a bit at each move of sck_out to capture level
    task automatic collect(input int n);
        g_bits = '0; g_nb = 0; g_act = 0; g_irq = 0;
        for (int i = 0; i < n; i++) begin
            step();
            tx_wr = 1'b0;
            if (active) g_act++;
            if (irq) g_irq++;
            if (sck_out != edge_rise && g_pv == edge_rise) begin
                g_bits = {g_bits[14:0], sd_out};
                g_nb++;
            end
            g_pv = sck_out;
        end
    endtask

    task automatic send_ext(input logic [DW-1:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sd_in = b[DW-1-i];
            repeat (4) step();
            sck_in = ~edge_rise;
            repeat (4) step();
            sck_in = edge_rise;
            repeat (4) step();
        end
    endtask

    task automatic t_reset();
        repeat (4) step();
        rst_n = 1'b1;
        step();
        check(ready == 1'b0, "R2 reset ready", ready, 0);
        check(active == 1'b0, "R2 reset active", active, 0);
        check(irq == 1'b0, "R2 reset irq", irq, 0);
        check(sd_oe == 1'b1, "R2 reset direction", sd_oe, 1);
    endtask

    task automatic t_tx_sys();
        dir_tx = 1; clk_int = 1; clk_src = 0; edge_rise = 1;
        irq_mask = 0; irq_on_end = 0; port_off = 0;
        repeat (6) step();
        check(active == 1'b0, "R3 no start while empty", active, 0);
        check(sck_oe == 1'b1, "R7 clock driven", sck_oe, 1);
        tx_data = 8'hA5; tx_wr = 1'b1; g_pv = sck_out;
        collect(44);
        check(g_bits[7:0] == 8'hA5, "R1 msb first", g_bits[7:0], 8'hA5);
        check(g_nb == 8, "R1 bit count", g_nb, 8);
        check(g_act == 16, "R7 R9 sysclk telegram length", g_act, 16);
        check(g_irq == 1, "R8 irq on ready fall", g_irq, 1);
        check(ready == 1'b0, "R2 tx buffer empty", ready, 0);
        check(sck_out == 1'b1, "R6 idle high", sck_out, 1);
        repeat (8) step();
        check(active == 1'b0, "R3 stall after drain", active, 0);
    endtask

    task automatic t_tx_timer_b2b();
        edge_rise = 0; clk_src = 1; irq_on_end = 1;
        repeat (3) step();
        tx_data = 8'h5A; tx_wr = 1'b1;
        step();
        tx_wr = 1'b0;
        check(ready == 1'b1, "R2 tx buffer full", ready, 1);
        for (int i = 0; i < 10 && !active; i++) step();
        check(active == 1'b1, "R3 start after write", active, 1);
        g_pv = sck_out;
        tx_data = 8'h81; tx_wr = 1'b1;
        collect(260);
        check(g_bits == 16'h5A81, "R1 back to back bytes", g_bits, 16'h5A81);
        check(g_irq == 2, "R8 irq per telegram end", g_irq, 2);
        check(g_act >= 170, "R7 timer paced clock", g_act, 170);
        check(active == 1'b0, "R9 idle after stream", active, 0);
        check(sck_out == 1'b0, "R6 idle low", sck_out, 0);
    endtask

    task automatic t_rx();
        int irq_base;
        port_off = 1; dir_tx = 0; clk_int = 0; edge_rise = 1;
        sck_in = 1; sd_in = 0; irq_mask = 1;
        repeat (4) step();
        check(ready == 1'b1, "R2 rx buffer empty", ready, 1);
        irq_base = irq_total;
        port_off = 0;
        step();
        check(active == 1'b1, "R10 auto start", active, 1);
        send_ext(8'h3C, 8);
        check(rx_data == 8'h3C, "R10 first byte", rx_data, 8'h3C);
        check(ready == 1'b0, "R10 buffer full", ready, 0);
        send_ext(8'hC3, 8);
        repeat (10) step();
        check(rx_data == 8'h3C, "R4 no overwrite", rx_data, 8'h3C);
        check(active == 1'b0, "R4 stalled", active, 0);
        rx_rd = 1'b1;
        step();
        rx_rd = 1'b0;
        check(ready == 1'b1, "R4 freed", ready, 1);
        step();
        check(ready == 1'b0, "R4 held byte moved", ready, 0);
        check(rx_data == 8'hC3, "R4 held byte", rx_data, 8'hC3);
        step();
        check(active == 1'b1, "R4 resumed", active, 1);
        check(irq_total == irq_base, "R8 masked", irq_total - irq_base, 0);
    endtask

    task automatic t_abort();
        rx_rd = 1'b1;
        step();
        rx_rd = 1'b0;
        check(ready == 1'b1, "R2 rx read", ready, 1);
        irq_mask = 0; irq_on_end = 0;
        send_ext(8'hA0, 3);
        port_off = 1'b1;
        step();
        check(active == 1'b0, "R5 stopped", active, 0);
        check(rx_data == 8'h05, "R5 partial byte", rx_data, 8'h05);
        check(ready == 1'b0, "R5 buffer full", ready, 0);
        check(irq == 1'b1, "R8 rx ready fall", irq, 1);
        step();
        check(irq == 1'b0, "R8 pulse width", irq, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_tx_sys();
        t_tx_timer_b2b();
        t_rx();
        t_abort();
        finish_run();
    end
endmodule